// File: doc/BRIEF.md
# LCD Multiplex Frame Sequencer

This block produces the digital timing for a multiplexed liquid-crystal drive. From one input clock it builds a fixed frame of `FRAME_CLKS` clocks. It walks through the backplane rows that the selected multiplex mode uses, and it gives every frame the opposite polarity to the one before. The two frames together therefore leave no DC component on the glass. For each of four backplanes it emits a 2-bit drive-state code. For each of 32 segments it emits a 2-bit code that combines the frame polarity with the display bit of the active row. An analog stage after the block turns these codes into voltages.

The display memory sits outside the block and offers a combinational read port. The block sweeps that port one column per clock and keeps a local copy of every column's 4-bit word, so all 32 segments can be driven in parallel. Several units can be cascaded. The frame-start pulse of one unit feeds the sync input of the next, and a pulse on that input restarts the frame.

The frame timer is a state machine with four states, `ROW_0`, `ROW_1`, `ROW_2` and `ROW_3`, one for each active backplane row. It has three kinds of transition:
- **advance**: at the end of a row slot the machine moves from `ROW_n` to `ROW_n+1`.
- **wrap**: at the end of the slot in `ROW_3` it moves to `ROW_0`.
- **restart**: at a frame boundary it moves from any state to `ROW_0`. A frame boundary is either the last clock of the frame or a sync input pulse. Restart takes priority over advance.

Top module: `lcd_frame_seq`

## Requirements
- R1: With no sync input, `sync_out` is high for exactly one clock out of every 24, and that clock is the first clock of a frame. The first clock after reset is also the first clock of a frame.
- R2: A frame is split into equal row slots: static mode has one slot of 24 clocks, 1:2 mode has 12 clocks per row, 1:3 mode has 8 and 1:4 mode has 6. Rows are visited in the order 0, 1, 2, 3.
- R3: A backplane code is 2'b01 (selected, positive) while its row is active in a positive frame and 2'b10 (selected, negative) in a negative frame. At all other times it is 2'b00 (not selected). Backplane k occupies bits [2k+1:2k] of `bp_code`.
- R4: Backplanes map to rows according to the mode. In static mode all four backplanes follow row 0. In 1:2 mode backplane 2 follows backplane 0 and backplane 3 follows backplane 1. In 1:3 mode backplane 3 follows backplane 1. In 1:4 mode backplane k follows row k.
- R5: Polarity starts positive after reset and inverts at every frame boundary.
- R6: The code for segment c sits in bits [2c+1:2c] of `seg_code` and equals {polarity, bit r of column c}. Here r is the active row, and polarity is 0 for positive and 1 for negative.
- R7: `col_addr` steps through 0 .. 31 by one per clock and then wraps. The `col_word` presented at address c is stored as column c's local copy on that clock's edge.
- R8: When `sync_in` is high at a clock edge, the next cycle is the first of a new frame: row 0 is active, `sync_out` is high and polarity has inverted.
- R9: `mode_sel` takes effect only at a frame boundary. The codes are 00 static, 01 1:2, 10 1:3 and 11 1:4.
- R10: Reset is asynchronous and active low. In reset the block is at the first clock of a positive static frame with a cleared local copy and `col_addr` at 0, so `bp_code` is 8'h55 and `seg_code` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Frame clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_sel | input | 2 | Requested multiplex mode |
| col_word | input | 4 | Display memory word at `col_addr` (bit r = row r) |
| sync_in | input | 1 | Cascade frame-restart pulse |
| bp_code | output | 8 | Four 2-bit backplane drive-state codes |
| seg_code | output | 64 | Thirty-two 2-bit segment codes |
| sync_out | output | 1 | High on the first clock of each frame |
| col_addr | output | 5 | Display memory column read address |

## Verification
The bench builds the block with its default parameters: a 24-clock frame and 32 segments. Those values make every mode's slot length a whole number of clocks, and they make the memory sweep longer than a frame. The bench can therefore catch a stale local copy that lingers across a frame boundary, as well as a mode change that lands in the middle of a frame, a sync pulse in the same cycle as a mode change, and polarity inversion across many frames.

// File: rtl/lcd_seq_pkg.sv
package lcd_seq_pkg;

    localparam int NUM_BP = 4;

    typedef enum logic [1:0] {
        MODE_STATIC = 2'b00,
        MODE_MUX2   = 2'b01,
        MODE_MUX3   = 2'b10,
        MODE_MUX4   = 2'b11
    } mux_mode_e;

    typedef enum logic [1:0] {
        BP_IDLE    = 2'b00,
        BP_SEL_POS = 2'b01,
        BP_SEL_NEG = 2'b10
    } bp_code_e;

    typedef enum logic [1:0] {
        ROW_0 = 2'd0,
        ROW_1 = 2'd1,
        ROW_2 = 2'd2,
        ROW_3 = 2'd3
    } row_state_e;

    // Row that physical backplane k follows in a given mode.
    function automatic logic [1:0] bp_row(input mux_mode_e m, input int unsigned k);
        logic [1:0] kk;
        kk = 2'(k);
        unique case (m)
            MODE_STATIC: bp_row = 2'd0;
            MODE_MUX2:   bp_row = {1'b0, kk[0]};
            MODE_MUX3:   bp_row = (kk == 2'd3) ? 2'd1 : kk;
            MODE_MUX4:   bp_row = kk;
        endcase
    endfunction

endpackage

// File: rtl/lcd_frame_timer.sv
module lcd_frame_timer
    import lcd_seq_pkg::*;
#(
    parameter int FRAME_CLKS = 24
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sync_in,
    input  mux_mode_e  mode_in,
    output row_state_e row,
    output logic       pol,
    output mux_mode_e  mode_act,
    output logic       frame_start
);

    localparam int TICK_W = $clog2(FRAME_CLKS);
    localparam int SLOT_1 = FRAME_CLKS;
    localparam int SLOT_2 = FRAME_CLKS / 2;
    localparam int SLOT_3 = FRAME_CLKS / 3;
    localparam int SLOT_4 = FRAME_CLKS / 4;

    logic [TICK_W-1:0] tick_q;
    logic [TICK_W-1:0] slot_q;
    row_state_e        state_q;
    row_state_e        state_d;
    mux_mode_e         mode_q;
    logic              pol_q;
    logic              frame_end;
    logic              slot_end;

    always_comb begin
        frame_end = sync_in || (tick_q == TICK_W'(FRAME_CLKS - 1));
        unique case (mode_q)
            MODE_STATIC: slot_end = (slot_q == TICK_W'(SLOT_1 - 1));
            MODE_MUX2:   slot_end = (slot_q == TICK_W'(SLOT_2 - 1));
            MODE_MUX3:   slot_end = (slot_q == TICK_W'(SLOT_3 - 1));
            MODE_MUX4:   slot_end = (slot_q == TICK_W'(SLOT_4 - 1));
        endcase
    end

    // Next-state: restart beats advance/wrap
    always_comb begin
        state_d = state_q;
        if (frame_end) begin
            state_d = ROW_0;
        end else if (slot_end) begin
            unique case (state_q)
                ROW_0: state_d = ROW_1;
                ROW_1: state_d = ROW_2;
                ROW_2: state_d = ROW_3;
                ROW_3: state_d = ROW_0;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ROW_0;
            tick_q  <= '0;
            slot_q  <= '0;
            pol_q   <= 1'b0;
            mode_q  <= MODE_STATIC;
        end else begin
            state_q <= state_d;
            if (frame_end) begin
                tick_q <= '0;
                slot_q <= '0;
                pol_q  <= ~pol_q;
                mode_q <= mode_in;
            end else begin
                tick_q <= tick_q + 1'b1;
                slot_q <= slot_end ? '0 : slot_q + 1'b1;
            end
        end
    end

    // Outputs
    always_comb begin
        row         = state_q;
        pol         = pol_q;
        mode_act    = mode_q;
        frame_start = (tick_q == '0);
    end

endmodule

// File: rtl/lcd_seg_shadow.sv
module lcd_seg_shadow #(
    parameter int NUM_SEG = 32,
    parameter int ADDR_W  = (NUM_SEG > 1) ? $clog2(NUM_SEG) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [3:0]              col_word,
    output logic [ADDR_W-1:0]       col_addr,
    output logic [NUM_SEG-1:0][3:0] shadow
);

    logic [ADDR_W-1:0] addr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
            shadow <= '0;
        end else begin
            shadow[addr_q] <= col_word;
            addr_q <= (addr_q == ADDR_W'(NUM_SEG - 1)) ? '0 : addr_q + 1'b1;
        end
    end

    assign col_addr = addr_q;

endmodule

// File: rtl/lcd_bp_encoder.sv
module lcd_bp_encoder
    import lcd_seq_pkg::*;
(
    input  mux_mode_e          mode,
    input  row_state_e         row,
    input  logic               pol,
    output logic [2*NUM_BP-1:0] bp_code
);

    for (genvar k = 0; k < NUM_BP; k++) begin : g_bp
        logic [1:0] map_row;
        assign map_row = bp_row(mode, k);
        always_comb begin
            if (map_row == row) begin
                bp_code[2*k +: 2] = pol ? BP_SEL_NEG : BP_SEL_POS;
            end else begin
                bp_code[2*k +: 2] = BP_IDLE;
            end
        end
    end

endmodule

// File: rtl/lcd_seg_encoder.sv
module lcd_seg_encoder
    import lcd_seq_pkg::*;
#(
    parameter int NUM_SEG = 32
) (
    input  logic [NUM_SEG-1:0][3:0] shadow,
    input  row_state_e              row,
    input  logic                    pol,
    output logic [2*NUM_SEG-1:0]    seg_code
);

    for (genvar c = 0; c < NUM_SEG; c++) begin : g_seg
        assign seg_code[2*c +: 2] = {pol, shadow[c][row]};
    end

endmodule

// File: rtl/lcd_frame_seq.sv
module lcd_frame_seq
    import lcd_seq_pkg::*;
#(
    parameter int FRAME_CLKS = 24,
    parameter int NUM_SEG    = 32,
    parameter int ADDR_W     = (NUM_SEG > 1) ? $clog2(NUM_SEG) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [1:0]            mode_sel,
    input  logic [3:0]            col_word,
    input  logic                  sync_in,
    output logic [2*NUM_BP-1:0]   bp_code,
    output logic [2*NUM_SEG-1:0]  seg_code,
    output logic                  sync_out,
    output logic [ADDR_W-1:0]     col_addr
);

    row_state_e              act_row;
    logic                    frame_pol;
    mux_mode_e               mode_act;
    logic [NUM_SEG-1:0][3:0] shadow;

    lcd_frame_timer #(.FRAME_CLKS(FRAME_CLKS)) u_timer (
        .clk         (clk),
        .rst_n       (rst_n),
        .sync_in     (sync_in),
        .mode_in     (mux_mode_e'(mode_sel)),
        .row         (act_row),
        .pol         (frame_pol),
        .mode_act    (mode_act),
        .frame_start (sync_out)
    );

    lcd_seg_shadow #(.NUM_SEG(NUM_SEG), .ADDR_W(ADDR_W)) u_shadow (
        .clk      (clk),
        .rst_n    (rst_n),
        .col_word (col_word),
        .col_addr (col_addr),
        .shadow   (shadow)
    );

    lcd_bp_encoder u_bp (
        .mode    (mode_act),
        .row     (act_row),
        .pol     (frame_pol),
        .bp_code (bp_code)
    );

    lcd_seg_encoder #(.NUM_SEG(NUM_SEG)) u_seg (
        .shadow   (shadow),
        .row      (act_row),
        .pol      (frame_pol),
        .seg_code (seg_code)
    );

endmodule

// File: rtl/lcd_frame_seq_chk.sv
module lcd_frame_seq_chk #(
    parameter int FRAME_CLKS = 24,
    parameter int NUM_SEG    = 32,
    parameter int ADDR_W     = (NUM_SEG > 1) ? $clog2(NUM_SEG) : 1
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 sync_in,
    input logic                 sync_out,
    input logic                 pol,
    input logic [1:0]           mode_q,
    input logic [7:0]           bp_code,
    input logic [2*NUM_SEG-1:0] seg_code,
    input logic [ADDR_W-1:0]    col_addr
);

    logic        past_ok;
    logic        had_prev;
    logic        sin_seen;
    int unsigned gap;
    logic [3:0]  bp_sel;
    logic [NUM_SEG-1:0] seg_pol;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            past_ok  <= 1'b0;
            had_prev <= 1'b0;
            sin_seen <= 1'b0;
            gap      <= 0;
        end else begin
            past_ok <= 1'b1;
            if (sync_out) begin
                had_prev <= 1'b1;
                sin_seen <= sync_in;
                gap      <= 1;
            end else begin
                if (sync_in) sin_seen <= 1'b1;
                gap <= gap + 1;
            end
        end
    end

    always_comb begin
        for (int k = 0; k < 4; k++) bp_sel[k] = |bp_code[2*k +: 2];
        for (int c = 0; c < NUM_SEG; c++) seg_pol[c] = seg_code[2*c+1];
    end

    AST_FRAME_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_out && had_prev && !sin_seen) |-> (gap == FRAME_CLKS)); // R1

    AST_SYNC_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_out && !sync_in) |=> !sync_out); // R1

    AST_MUX4_ONE_BP: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == 2'b11) |-> ($countones(bp_sel) == 1)); // R4

    AST_BP_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (bp_code[1:0] != 2'b11) && (bp_code[3:2] != 2'b11) &&
        (bp_code[5:4] != 2'b11) && (bp_code[7:6] != 2'b11)); // R3

    AST_SEG_POL: assert property (@(posedge clk) disable iff (!rst_n)
        seg_pol == {NUM_SEG{pol}}); // R6

    AST_SYNC_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
        sync_in |=> (pol != $past(pol))); // R8

    AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !sync_out |-> $stable(mode_q)); // R9

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok |-> (col_addr == (($past(col_addr) == ADDR_W'(NUM_SEG - 1)) ?
                                  '0 : $past(col_addr) + 1'b1))); // R7

endmodule

bind lcd_frame_seq lcd_frame_seq_chk #(
    .FRAME_CLKS (FRAME_CLKS),
    .NUM_SEG    (NUM_SEG),
    .ADDR_W     (ADDR_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sync_in  (sync_in),
    .sync_out (sync_out),
    .pol      (frame_pol),
    .mode_q   (mode_act),
    .bp_code  (bp_code),
    .seg_code (seg_code),
    .col_addr (col_addr)
);

// File: tb/lcd_frame_seq_test.sv
`timescale 1ns/1ps
module lcd_frame_seq_test;

    localparam int FR   = 24;
    localparam int NSEG = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  mode_sel = 2'b00;
    logic [3:0]  col_word;
    logic        sync_in = 1'b0;
    logic [7:0]  bp_code;
    logic [63:0] seg_code;
    logic        sync_out;
    logic [4:0]  col_addr;

    logic [3:0] mem [NSEG];

    int tests = 0;
    int fails = 0;
    bit done  = 0;

    // reference model state
    int       m_tick, m_mode, m_addr;
    bit       m_pol;
    logic [3:0] sh [NSEG];

    always #2.5 clk = ~clk;

    assign col_word = mem[col_addr];

    lcd_frame_seq uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_sel (mode_sel),
        .col_word (col_word),
        .sync_in  (sync_in),
        .bp_code  (bp_code),
        .seg_code (seg_code),
        .sync_out (sync_out),
        .col_addr (col_addr)
    );

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_tick = 0; m_pol = 0; m_mode = 0; m_addr = 0;
            for (int c = 0; c < NSEG; c++) sh[c] = 4'h0;
        end else begin
            sh[m_addr] = mem[m_addr];
            m_addr = (m_addr + 1) % NSEG;
            if (m_tick == FR - 1 || sync_in) begin
                m_tick = 0; m_pol = ~m_pol; m_mode = mode_sel;
            end else begin
                m_tick = m_tick + 1;
            end
        end
    end

    function automatic int m_row();
        return m_tick / (FR / (m_mode + 1));
    endfunction

    function automatic int logical_row(int mode, int k);
        case (mode)
            0: return 0;
            1: return k % 2;
            2: return (k == 3) ? 1 : k;
            default: return k;
        endcase
    endfunction

    function automatic logic [7:0] exp_bp();
        logic [7:0] v;
        for (int k = 0; k < 4; k++)
            v[2*k +: 2] = (logical_row(m_mode, k) == m_row()) ?
                          (m_pol ? 2'b10 : 2'b01) : 2'b00;
        return v;
    endfunction

    function automatic logic [63:0] exp_seg();
        logic [63:0] v;
        for (int c = 0; c < NSEG; c++) v[2*c +: 2] = {m_pol, sh[c][m_row()]};
        return v;
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // compare against the model on every negedge
    task automatic step();
        @(negedge clk);
        check("R1 R8 sync_out", 64'(sync_out), 64'(m_tick == 0));
        check("R2 R3 R4 R9 bp_code", 64'(bp_code), 64'(exp_bp()));
        check("R5 R6 seg_code", seg_code, exp_seg());
        check("R7 col_addr", 64'(col_addr), 64'(m_addr));
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic fill(input int seed);
        for (int c = 0; c < NSEG; c++) mem[c] = 4'((c * 7 + seed) ^ (c >> 2));
    endtask

    task automatic wait_frame();
        int guard = 0;
        step();
        while (!sync_out && guard < 100) begin step(); guard++; end
    endtask

    initial begin
        int n;
        fill(3);
        repeat (3) @(negedge clk);
        // R10: reset state
        check("R10 bp_code in reset", 64'(bp_code), 64'h55);
        check("R10 seg_code in reset", seg_code, 64'h0);
        check("R10 col_addr in reset", 64'(col_addr), 64'h0);
        check("R10 sync_out in reset", 64'(sync_out), 64'h1);
        mode_sel = 2'b11;
        rst_n = 1'b1;
        run(30);

        // R2: 1:3 slot length, R1: frame length
        mode_sel = 2'b10;
        wait_frame();
        n = 0;
        while (bp_code[1:0] != 2'b00 && n < 40) begin n++; step(); end
        check("R2 1:3 row slot length", 64'(n), 64'd8);
        wait_frame();
        n = 0;
        do begin step(); n++; end while (!sync_out && n < 40);
        check("R1 frame length", 64'(n), 64'd24);

        // R2: 1:2 slot length
        mode_sel = 2'b01;
        wait_frame();
        n = 0;
        while (bp_code[1:0] != 2'b00 && n < 40) begin n++; step(); end
        check("R2 1:2 row slot length", 64'(n), 64'd12);
        check("R4 1:2 bp3 mirrors bp1", 64'(bp_code[7:6]), 64'(bp_code[3:2]));

        // R9: mid-frame mode change held off
        run(5);
        mode_sel = 2'b00;
        step();
        check("R9 mode held mid-frame", 64'(bp_code[5:4] == 2'b00 || bp_code[1:0] == 2'b00), 64'd1);
        run(40);

        // R7: new memory contents reach segments
        fill(11);
        run(50);

        // R8: sync pulse mid-frame, together with mode change
        run(7);
        sync_in = 1'b1; mode_sel = 2'b11;
        step();
        sync_in = 1'b0;
        check("R8 sync restarts frame", 64'(sync_out), 64'd1);
        check("R8 R4 row 0 on bp0 only", 64'(bp_code[7:2]), 64'd0);
        run(30);
        sync_in = 1'b1; step(); sync_in = 1'b0;
        run(3);
        sync_in = 1'b1; step(); step(); sync_in = 1'b0;
        run(60);

        // sweep all modes with fresh data
        for (int md = 0; md < 4; md++) begin
            mode_sel = 2'(md);
            fill(md * 5 + 1);
            run(60);
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule